// File: doc/BRIEF.md
# Stream-to-Buffer Ring Channel Manager

This block is the device-side engine of one device-to-host data channel. Words arrive on a valid/ready stream and are written, one per cycle, through a plain memory-write port into a ring of equally sized host buffers. Each buffer is owned either by the device, which may fill it, or by the host, which is reading it. When the buffer being filled becomes full, the block hands it to the host. It then posts a release message carrying the buffer index and the number of valid bytes, and moves on to the next buffer in ring order.

A partly filled buffer is handed over only when the host asks for it by writing a flush command. The host returns a buffer to the device by writing that buffer's index through the same register port. If the channel was completely empty and receives its first word, the block can also post a one-time "nonempty" notice, which lets the host implement polling. All notices pass through a small queue that feeds the shared message channel 0. Each message placed in the queue raises a one-cycle interrupt request.

Top module: `ring_channel_mgr`

## Requirements
- R1: Accepted words are written in arrival order. Word w of buffer b goes to word address b*WORDS+w, where WORDS = BUF_BYTES/(WORD_BITS/8). The address is the buffer index in the upper bits and the word offset in the lower bits. The write appears on the memory port one cycle after acceptance.
- R2: When the last word of a buffer is accepted, a release message is queued. It carries opcode 1, the channel number, the index of that buffer and a byte count of BUF_BYTES. Filling then continues in the next buffer in ring order.
- R3: A partly filled buffer is never released unless the host asks for it. After a flush command (host_cmd=1), the buffer is released as soon as possible, with a byte count of words*(WORD_BITS/8), and filling moves to the next buffer.
- R4: A flush command that finds the current buffer empty queues no message, leaves the write position unchanged, and the input is accepted again afterwards.
- R5: A released buffer belongs to the host. It is not written again until the host writes its index with host_cmd=0. Index values of NUM_BUFS or above are ignored.
- R6: in_ready is low whenever the current buffer belongs to the host, so no data is overwritten.
- R7: The first word accepted by a channel that holds no data (every buffer device-owned and the current buffer empty) queues one nonempty message. It carries opcode 2, the channel number, the current buffer index and a byte count of 0. When cfg_nonempty_en is low, this message is not sent.
- R8: A message word is laid out as opcode in bits 31:28, channel in 27:20, buffer index in 19:12 and byte count in 11:0.
- R9: Messages leave in the order they were queued. Each queued message raises irq for exactly one cycle. While the queue is full, a pending release waits and the input stays stalled. msg_data holds steady while msg_valid is high and msg_ready is low.
- R10: After reset, msg_valid, irq and mem_we are low and in_ready is high. Filling restarts at buffer 0 with every buffer device-owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream word valid |
| in_data | input | WORD_BITS | Stream word |
| in_ready | output | 1 | Stream word accepted when high with in_valid |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | log2(NUM_BUFS*WORDS) | Buffer memory word address |
| mem_wdata | output | WORD_BITS | Buffer memory write data |
| host_we | input | 1 | Host register write strobe |
| host_cmd | input | 1 | 0: return buffer, 1: flush request |
| host_wdata | input | 8 | Buffer index for a return command |
| cfg_nonempty_en | input | 1 | Enables nonempty messages |
| msg_valid | output | 1 | Message available on channel 0 |
| msg_data | output | 32 | Message word |
| msg_ready | input | 1 | Consumer takes the message |
| irq | output | 1 | One-cycle interrupt request per queued message |

## Verification
The bench builds the block with 16-bit words, 16-byte buffers (eight words), four buffers, channel number 3 and a message queue only two entries deep. Short buffers make a full trip around the ring, and the state where every buffer belongs to the host, cheap to reach. Two-byte words make partial byte counts differ from word counts. The two-entry queue fills after two releases, so the wait for queue space and the stalled input can be observed directly.

// File: rtl/ring_mgr_pkg.sv
package ring_mgr_pkg;
  localparam logic [3:0] OP_RELEASE  = 4'd1;
  localparam logic [3:0] OP_NONEMPTY = 4'd2;

  typedef struct packed {
    logic [3:0]  opcode;
    logic [7:0]  chan;
    logic [7:0]  index;
    logic [11:0] bytes;
  } ring_msg_t;
endpackage

// File: rtl/ring_buf_owner.sv
module ring_buf_owner #(
  parameter int NUM_BUFS = 4,
  localparam int IDX_W = $clog2(NUM_BUFS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take_en,
  input  logic [IDX_W-1:0]    take_idx,
  input  logic                give_en,
  input  logic [IDX_W-1:0]    give_idx,
  output logic [NUM_BUFS-1:0] host_owned,
  output logic                all_device
);
  // one ownership flag per buffer; taking wins over giving on the same index
  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        host_owned[b] <= 1'b0;
      else if (take_en && take_idx == IDX_W'(b))
        host_owned[b] <= 1'b1;
      else if (give_en && give_idx == IDX_W'(b))
        host_owned[b] <= 1'b0;
    end
  end

  assign all_device = (host_owned == '0);

  // the writer must never hand over a buffer the host already holds
  assert_take_device_owned_R5: assert property (@(posedge clk) disable iff (rst)
    take_en |-> !host_owned[take_idx]);
endmodule

// File: rtl/ring_msg_fifo.sv
module ring_msg_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop_req,
  output logic         valid,
  output logic [W-1:0] dout
);
  logic [W-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          pop;

  assign full  = (cnt == (PW+1)'(DEPTH));
  assign valid = (cnt != '0);
  assign pop   = pop_req && valid;
  assign dout  = store[rp];

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop)  rp <= rp + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + (PW+1)'(1);
        2'b01:   cnt <= cnt - (PW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  assert_head_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && !pop_req) |=> (valid && $stable(dout)));
endmodule

// File: rtl/ring_channel_mgr.sv
module ring_channel_mgr
  import ring_mgr_pkg::*;
#(
  parameter int WORD_BITS  = 32,
  parameter int BUF_BYTES  = 64,
  parameter int NUM_BUFS   = 4,
  parameter int MSGQ_DEPTH = 4,
  parameter int CHAN_ID    = 1,
  localparam int BPW    = WORD_BITS / 8,
  localparam int WORDS  = BUF_BYTES / BPW,
  localparam int WPTR_W = $clog2(WORDS),
  localparam int BIDX_W = $clog2(NUM_BUFS),
  localparam int ADDR_W = BIDX_W + WPTR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [WORD_BITS-1:0] in_data,
  output logic                 in_ready,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [WORD_BITS-1:0] mem_wdata,
  input  logic                 host_we,
  input  logic                 host_cmd,
  input  logic [7:0]           host_wdata,
  input  logic                 cfg_nonempty_en,
  output logic                 msg_valid,
  output logic [31:0]          msg_data,
  input  logic                 msg_ready,
  output logic                 irq
);
  // fill position
  logic [BIDX_W-1:0] wr_buf;
  logic [WPTR_W-1:0] wr_word;

  // pending notices waiting for queue space
  logic              rel_pend, ne_pend, flush_req;
  logic [BIDX_W-1:0] rel_idx, ne_idx;
  logic [11:0]       rel_bytes;

  logic [NUM_BUFS-1:0] host_owned;
  logic                all_device;
  logic                q_full, q_push;
  ring_msg_t           q_word;

  logic accept, last_word, chan_empty, flush_go, flush_cap, capture, give_en;

  assign in_ready   = !host_owned[wr_buf] && !rel_pend && !flush_req;
  assign accept     = in_valid && in_ready;
  assign last_word  = (wr_word == WPTR_W'(WORDS - 1));
  assign chan_empty = all_device && (wr_word == '0);
  assign flush_go   = flush_req && !rel_pend;
  assign flush_cap  = flush_go && (wr_word != '0);
  assign capture    = (accept && last_word) || flush_cap;
  assign give_en    = host_we && !host_cmd && (host_wdata < 8'(NUM_BUFS));

  // nonempty notice goes first when both wait
  assign q_push = (ne_pend || rel_pend) && !q_full;
  always_comb begin
    q_word.chan = 8'(CHAN_ID);
    if (ne_pend) begin
      q_word.opcode = OP_NONEMPTY;
      q_word.index  = 8'(ne_idx);
      q_word.bytes  = '0;
    end else begin
      q_word.opcode = OP_RELEASE;
      q_word.index  = 8'(rel_idx);
      q_word.bytes  = rel_bytes;
    end
  end

  // memory write port, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we <= 1'b0;
    end else begin
      mem_we <= accept;
    end
    if (accept) begin
      mem_addr  <= {wr_buf, wr_word};
      mem_wdata <= in_data;
    end
  end

  // fill position and release capture
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_buf    <= '0;
      wr_word   <= '0;
      rel_pend  <= 1'b0;
      rel_idx   <= '0;
      rel_bytes <= '0;
    end else begin
      if (accept) wr_word <= last_word ? '0 : wr_word + WPTR_W'(1);
      if (flush_cap) wr_word <= '0;
      if (capture) begin
        wr_buf    <= wr_buf + BIDX_W'(1);
        rel_pend  <= 1'b1;
        rel_idx   <= wr_buf;
        rel_bytes <= (accept && last_word) ? 12'(BUF_BYTES)
                                           : 12'(wr_word) * 12'(BPW);
      end else if (q_push && !ne_pend) begin
        rel_pend <= 1'b0;
      end
    end
  end

  // flush request and nonempty notice
  always_ff @(posedge clk) begin
    if (rst) begin
      flush_req <= 1'b0;
      ne_pend   <= 1'b0;
      ne_idx    <= '0;
      irq       <= 1'b0;
    end else begin
      if (host_we && host_cmd) flush_req <= 1'b1;
      else if (flush_go)       flush_req <= 1'b0;

      if (accept && chan_empty && cfg_nonempty_en) begin
        ne_pend <= 1'b1;
        ne_idx  <= wr_buf;
      end else if (q_push && ne_pend) begin
        ne_pend <= 1'b0;
      end

      irq <= q_push;
    end
  end

  ring_buf_owner #(.NUM_BUFS(NUM_BUFS)) u_owner (
    .clk        (clk),
    .rst        (rst),
    .take_en    (capture),
    .take_idx   (wr_buf),
    .give_en    (give_en),
    .give_idx   (host_wdata[BIDX_W-1:0]),
    .host_owned (host_owned),
    .all_device (all_device)
  );

  ring_msg_fifo #(.DEPTH(MSGQ_DEPTH), .W(32)) u_msgq (
    .clk     (clk),
    .rst     (rst),
    .push    (q_push),
    .din     (q_word),
    .full    (q_full),
    .pop_req (msg_ready),
    .valid   (msg_valid),
    .dout    (msg_data)
  );

  assert_irq_with_msg_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> irq);

  assert_release_bytes_R3: assert property (@(posedge clk) disable iff (rst)
    (q_push && !ne_pend) |-> (q_word.bytes != '0 && q_word.bytes <= 12'(BUF_BYTES)));

  assert_flush_needs_data_R4: assert property (@(posedge clk) disable iff (rst)
    (flush_go && $past(wr_word) == '0 && $past(!accept)) |=> $stable(wr_buf));
endmodule

// File: tb/test_ring_channel_mgr.sv
`timescale 1ns/1ps
module test_ring_channel_mgr;
  localparam int WB = 16, BB = 16, NB = 4, QD = 2, CH = 3;
  localparam int WPB = BB / (WB/8);
  localparam int AW  = $clog2(NB) + $clog2(WPB);
  localparam int K_SEND = 1, K_FLUSH = 2, K_FREE = 3, K_MSG = 4, K_NONE = 5, K_RDY = 6;
  localparam int NV = 26;
  localparam logic [35:0] TBL [NV] = '{
    {4'd1, 32'd3},
    {4'd4, 4'd2, 8'd3, 8'd0, 12'd0},
    {4'd1, 32'd5},
    {4'd4, 4'd1, 8'd3, 8'd0, 12'd16},
    {4'd1, 32'd2},
    {4'd5, 32'd8},
    {4'd2, 32'd0},
    {4'd4, 4'd1, 8'd3, 8'd1, 12'd4},
    {4'd2, 32'd0},
    {4'd5, 32'd6},
    {4'd6, 32'd1},
    {4'd1, 32'd8},
    {4'd4, 4'd1, 8'd3, 8'd2, 12'd16},
    {4'd1, 32'd8},
    {4'd4, 4'd1, 8'd3, 8'd3, 12'd16},
    {4'd6, 32'd0},
    {4'd3, 32'd0},
    {4'd6, 32'd1},
    {4'd1, 32'd8},
    {4'd4, 4'd1, 8'd3, 8'd0, 12'd16},
    {4'd3, 32'd1},
    {4'd3, 32'd2},
    {4'd3, 32'd3},
    {4'd3, 32'd0},
    {4'd1, 32'd1},
    {4'd4, 4'd2, 8'd3, 8'd1, 12'd0}
  };

  logic clk = 0, rst = 1;
  logic in_valid = 0, host_we = 0, host_cmd = 0, cfg_ne = 1, msg_ready = 0;
  logic [WB-1:0] in_data = '0;
  logic [7:0] host_wdata = '0;
  logic in_ready, mem_we, msg_valid, irq;
  logic [AW-1:0] mem_addr;
  logic [WB-1:0] mem_wdata;
  logic [31:0] msg_data;

  int errors = 0, checks = 0, cycles = 0, irq_cnt = 0, msgs = 0, viol = 0;
  int cur_buf = 0, cur_word = 0;
  logic [WB-1:0] seq = 16'h1000;
  logic [WB-1:0] exp_mem [NB*WPB];
  logic [WB-1:0] got_mem [NB*WPB];
  bit b_owned [NB];

  always #5 clk = ~clk;

  ring_channel_mgr #(.WORD_BITS(WB), .BUF_BYTES(BB), .NUM_BUFS(NB),
                     .MSGQ_DEPTH(QD), .CHAN_ID(CH)) i_ring_channel_mgr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .host_we(host_we), .host_cmd(host_cmd), .host_wdata(host_wdata),
    .cfg_nonempty_en(cfg_ne), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_ready(msg_ready), .irq(irq));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: memory image, ownership violations, interrupt cycles
  always @(negedge clk) begin
    cycles++;
    if (!rst && mem_we) begin
      got_mem[mem_addr] = mem_wdata;
      if (b_owned[mem_addr / WPB]) viol++;
    end
    if (!rst && irq) irq_cnt++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d expected <20000 cycles", cycles);
      summary();
    end
  end

  task automatic send_words(input int n);
    for (int k = 0; k < n; k++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_data = seq;
      exp_mem[cur_buf*WPB + cur_word] = seq;
      seq = seq + 16'h0101;
      cur_word++;
      if (cur_word == WPB) begin cur_word = 0; cur_buf = (cur_buf + 1) % NB; end
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic host_write(input logic cmd, input int val);
    host_we = 1; host_cmd = cmd; host_wdata = 8'(val);
    if (cmd && cur_word != 0) begin cur_word = 0; cur_buf = (cur_buf + 1) % NB; end
    if (!cmd && val < NB) b_owned[val] = 0;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic expect_msg(input logic [31:0] exp);
    for (int w = 0; w < 50 && !msg_valid; w++) @(negedge clk);
    chk(msg_valid && msg_data == exp, "R2/R3/R7/R8 message", msg_data, exp);
    if (msg_valid) begin
      msgs++;
      if (msg_data[31:28] == 4'd1) b_owned[msg_data[19:12] % NB] = 1;
      msg_ready = 1;
      @(negedge clk);
      msg_ready = 0;
    end
  endtask

  task automatic expect_none(input int n, input string tag);
    bit seen = 0;
    for (int w = 0; w < n; w++) begin
      if (msg_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, tag, {31'd0, seen}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NB*WPB; i++) begin exp_mem[i] = '0; got_mem[i] = '0; end
    for (int i = 0; i < NB; i++) b_owned[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(in_ready && !msg_valid && !irq && !mem_we, "R10 reset outputs",
        {28'd0, in_ready, msg_valid, irq, mem_we}, 32'h8);

    for (int v = 0; v < NV; v++) begin
      case (int'(TBL[v][35:32]))
        K_SEND:  send_words(int'(TBL[v][31:0]));
        K_FLUSH: host_write(1'b1, 0);
        K_FREE:  host_write(1'b0, int'(TBL[v][31:0]));
        K_MSG:   expect_msg(TBL[v][31:0]);
        K_NONE:  expect_none(int'(TBL[v][31:0]), "R3/R4 no unrequested message");
        K_RDY:   chk(in_ready == TBL[v][0], "R4/R5/R6 in_ready", {31'd0, in_ready}, {31'd0, TBL[v][0]});
        default: ;
      endcase
    end

    // R5 out-of-range return index is ignored: buffer 1 stays writable, no change elsewhere
    host_write(1'b0, 9);
    chk(in_ready, "R5 out-of-range index ignored", {31'd0, in_ready}, 32'd1);

    // R9 queue full: two releases fill the queue, third waits and stalls input
    send_words(7);
    send_words(8);
    send_words(8);
    repeat (4) @(negedge clk);
    chk(!in_ready && msg_valid, "R9 stall while queue full",
        {30'd0, in_ready, msg_valid}, 32'd1);
    expect_msg({4'd1, 8'd3, 8'd1, 12'd16});
    expect_msg({4'd1, 8'd3, 8'd2, 12'd16});
    expect_msg({4'd1, 8'd3, 8'd3, 12'd16});
    host_write(1'b0, 1); host_write(1'b0, 2); host_write(1'b0, 3);

    // R7 nonempty suppressed when disabled (channel empty again, at buffer 0)
    cfg_ne = 0;
    send_words(1);
    expect_none(8, "R7 nonempty disabled");
    cfg_ne = 1;

    // R1 memory image and R5 no write into host-owned buffers
    for (int i = 0; i < NB*WPB; i++)
      chk(got_mem[i] == exp_mem[i], "R1 buffer memory word", {16'd0, got_mem[i]}, {16'd0, exp_mem[i]});
    chk(viol == 0, "R5 writes into host buffers", viol, 32'd0);
    chk(irq_cnt == msgs, "R9 one irq cycle per message", irq_cnt, msgs);

    // R10 reset mid-stream restarts at buffer 0
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < NB; i++) b_owned[i] = 0;
    cur_buf = 0; cur_word = 0;
    @(negedge clk);
    chk(in_ready && !msg_valid && !irq && !mem_we, "R10 reset after traffic",
        {28'd0, in_ready, msg_valid, irq, mem_we}, 32'h8);
    send_words(1);
    expect_msg({4'd2, 8'd3, 8'd0, 12'd0});
    summary();
  end
endmodule